// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Controller

This block is the slave side of a two-wire serial bus in front of a 128-byte memory. The clock and data lines are sampled with the system clock through short synchronizers. The block detects START and STOP conditions and shifts in the device byte, the word address and data bytes. It acknowledges by asserting a pull-low enable, which an open-drain pad turns into a low level on the data line. Reads return bytes from the array one after another for as long as the master keeps acknowledging.

Write data collects in an eight-entry page buffer. When more than eight bytes arrive, the newest byte replaces the oldest one. A STOP after at least one complete data byte starts a programming window of fixed length, during which the buffered bytes move into the array. While that window is open the block ignores the bus entirely and acknowledges nothing, not even its own device address. A START that arrives before the write has ended throws the buffered bytes away.

Top module: `twi_eeprom_slave`

## Requirements
- R1: While reset is high and in the first cycle after it, the pull-low enable `sda_oe_o` is 0.
- R2: The first byte after a START arrives MSB first, as a 7-bit device address followed by a direction bit (0 = write, 1 = read). The block acknowledges it when the 7 address bits equal `DEV_ADDR` and no programming window is open.
- R3: A device byte whose address differs from `DEV_ADDR` gets no acknowledge, and the block stays off the bus until the next START.
- R4: For every byte it receives while addressed (device byte, word address, data), the block holds the data line low for the whole high phase of the ninth clock. It asserts the pull only while the clock is low. Bytes are sent MSB first.
- R5: A read returns the byte at the word pointer and then the following addresses, one byte for each acknowledge from the master. The pointer wraps from 127 to 0.
- R6: When the master does not acknowledge a byte that was read, the block releases the data line and leaves it high.
- R7: When a write carries more than eight data bytes, only the last eight are kept. The oldest of the kept bytes lands at the first written address and the rest follow in order of arrival.
- R8: While a programming window is open, no byte is acknowledged, including a matching device byte.
- R9: A programming window opens on a STOP that follows at least one complete data byte and lasts `PROG_CYCLES` system clocks. After it closes, the block acknowledges again and the array holds the written bytes.
- R10: A START that arrives during a write (including part-way through a byte) discards the buffered bytes. No programming follows, and the array is left unchanged.
- R11: A STOP that ends a write with no complete data byte opens no programming window.
- R12: During a write, successive data bytes go to successive addresses, wrapping from 127 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (includes this block's own pull) |
| sda_oe_o | output | 1 | Pull-low enable for the open-drain data pad, registered |

## Verification
The block sees each bus edge two synchronizer cycles after the pin changes and reacts one register later. The pull-low enable therefore changes a few system clocks after a clock fall. The bench keeps every clock-low quarter period at eight system clocks, so the acknowledge and each read bit are settled before the clock rises. It samples them in the middle of the high phase, and an acknowledge is only counted if the line stays low through that entire high phase. Programming ends `PROG_CYCLES` clocks after the synchronized STOP. The bench probes for the lockout a few hundred clocks into that window, and checks recovery and array contents only after a wait longer than the window.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_RX,
    LK_RX_ACK,
    LK_TX,
    LK_TX_ACK
  } link_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WORD,
    PH_DATA
  } link_phase_e;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/twi_mem.sv
module twi_mem #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] arr [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      arr[waddr] <= wdata;
    end
    rdata <= arr[raddr];
  end

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int DW          = 8,
  parameter int AW          = 7,
  parameter int DEPTH       = 8,
  parameter int PROG_CYCLES = 600,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [AW-1:0] push_addr,
  input  logic          commit,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);

  logic [DW-1:0] ent [DEPTH];
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic [CW-1:0] n_left;
  logic [AW-1:0] base;
  logic [AW-1:0] waddr_q;
  logic [TW-1:0] timer;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  // storage: register file, no reset
  always_ff @(posedge clk) begin
    if (push && !busy && !clr) begin
      ent[wr_idx] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      wr_idx    <= '0;
      rd_idx    <= '0;
      n_left    <= '0;
      base      <= '0;
      waddr_q   <= '0;
      timer     <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        timer <= timer + 1'b1;
        if (n_left != '0) begin
          mem_we    <= 1'b1;
          mem_waddr <= waddr_q;
          mem_wdata <= ent[rd_idx];
          waddr_q   <= waddr_q + 1'b1;
          rd_idx    <= step(rd_idx);
          n_left    <= n_left - 1'b1;
        end
        if (timer == TW'(PROG_CYCLES - 1)) begin
          busy   <= 1'b0;
          cnt    <= '0;
          wr_idx <= '0;
        end
      end else if (commit && cnt != '0) begin
        busy    <= 1'b1;
        timer   <= '0;
        n_left  <= cnt;
        waddr_q <= base;
        rd_idx  <= (cnt == CW'(DEPTH)) ? wr_idx : '0;
      end else if (clr) begin
        cnt    <= '0;
        wr_idx <= '0;
      end else if (push) begin
        wr_idx <= step(wr_idx);
        if (cnt == '0) begin
          base <= push_addr;
        end
        if (cnt != CW'(DEPTH)) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/twi_link.sv
module twi_link
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         DW       = 8,
  parameter int         AW       = 7,
  localparam int        BW       = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          busy,
  input  logic [DW-1:0] mem_rdata,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic [AW-1:0] push_addr,
  output logic          buf_clr,
  output logic          commit
);

  link_state_e   state;
  link_phase_e   phase;
  logic          scl_q;
  logic          sda_q;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] tx_sh;
  logic          rw;
  logic          mack;

  logic start_ev, stop_ev, scl_rise, scl_fall;

  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LK_IDLE;
      phase     <= PH_DEV;
      bitcnt    <= '0;
      shreg     <= '0;
      tx_sh     <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      push      <= 1'b0;
      push_data <= '0;
      push_addr <= '0;
      buf_clr   <= 1'b0;
      commit    <= 1'b0;
    end else begin
      push    <= 1'b0;
      buf_clr <= 1'b0;
      commit  <= 1'b0;
      if (start_ev) begin
        state   <= LK_RX;
        phase   <= PH_DEV;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        buf_clr <= 1'b1;
      end else if (stop_ev) begin
        state  <= LK_IDLE;
        sda_oe <= 1'b0;
        commit <= 1'b1;
      end else begin
        unique case (state)
          LK_RX: begin
            if (scl_rise && bitcnt != BW'(DW)) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BW'(DW)) begin
              unique case (phase)
                PH_DEV: begin
                  if (shreg[DW-1:1] == DEV_ADDR && !busy) begin
                    rw     <= shreg[0];
                    sda_oe <= 1'b1;
                    state  <= LK_RX_ACK;
                  end else begin
                    state <= LK_IDLE;
                  end
                end
                PH_WORD: begin
                  ptr    <= shreg[AW-1:0];
                  sda_oe <= 1'b1;
                  state  <= LK_RX_ACK;
                end
                default: begin
                  push      <= 1'b1;
                  push_data <= shreg;
                  push_addr <= ptr;
                  ptr       <= ptr + 1'b1;
                  sda_oe    <= 1'b1;
                  state     <= LK_RX_ACK;
                end
              endcase
            end
          end
          LK_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (phase == PH_DEV && rw) begin
                tx_sh  <= mem_rdata;
                sda_oe <= ~mem_rdata[DW-1];
                state  <= LK_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= LK_RX;
                phase  <= (phase == PH_DEV) ? PH_WORD : PH_DATA;
              end
            end
          end
          LK_TX: begin
            if (scl_fall) begin
              if (bitcnt == BW'(DW - 1)) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                state  <= LK_TX_ACK;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                sda_oe <= ~tx_sh[DW-2];
              end
            end
          end
          LK_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                bitcnt <= '0;
                tx_sh  <= mem_rdata;
                sda_oe <= ~mem_rdata[DW-1];
                state  <= LK_TX;
              end else begin
                state <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         DW          = 8,
  parameter int         AW          = 7,
  parameter int         PAGE        = 8,
  parameter int         PROG_CYCLES = 600,
  parameter int         SYNC_STAGES = 2,
  localparam int        CW          = $clog2(PAGE + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  logic [1:0]    pins_raw;
  logic [1:0]    pins_syn;
  logic          scl_s;
  logic          sda_s;
  logic          busy;
  logic [CW-1:0] buf_cnt;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic [AW-1:0] ptr;
  logic [DW-1:0] mem_rdata;
  logic          push;
  logic [DW-1:0] push_data;
  logic [AW-1:0] push_addr;
  logic          buf_clr;
  logic          commit;

  assign pins_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pins_raw[g]),
      .q   (pins_syn[g])
    );
  end

  assign scl_s = pins_syn[0];
  assign sda_s = pins_syn[1];

  twi_link #(.DEV_ADDR(DEV_ADDR), .DW(DW), .AW(AW)) u_link (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .busy      (busy),
    .mem_rdata (mem_rdata),
    .sda_oe    (sda_oe_o),
    .ptr       (ptr),
    .push      (push),
    .push_data (push_data),
    .push_addr (push_addr),
    .buf_clr   (buf_clr),
    .commit    (commit)
  );

  twi_page_buf #(.DW(DW), .AW(AW), .DEPTH(PAGE), .PROG_CYCLES(PROG_CYCLES)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .clr       (buf_clr),
    .push      (push),
    .push_data (push_data),
    .push_addr (push_addr),
    .commit    (commit),
    .busy      (busy),
    .cnt       (buf_cnt),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  twi_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          busy,
  input logic          mem_we,
  input logic [CW-1:0] buf_cnt
);

  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !sda_oe); // R1
  AST_PULL_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_s); // R4
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> !sda_oe); // R8
  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) mem_we |-> busy); // R9
  AST_BUF_BOUNDED: assert property (@(posedge clk) disable iff (rst) buf_cnt <= CW'(DEPTH)); // R7

endmodule

bind twi_eeprom_slave twi_eeprom_chk #(.DEPTH(PAGE), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_s   (scl_s),
  .sda_oe  (sda_oe_o),
  .busy    (busy),
  .mem_we  (mem_we),
  .buf_cnt (buf_cnt)
);

// File: tb/test_twi_eeprom_slave.sv
module test_twi_eeprom_slave;

  localparam int         Q    = 8;
  localparam int         PROG = 600;
  localparam logic [6:0] DEV  = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;

  assign sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  twi_eeprom_slave #(.DEV_ADDR(DEV), .PROG_CYCLES(PROG)) i_twi_eeprom_slave (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  int         nchk = 0;
  int         nerr = 0;
  bit         done = 1'b0;
  logic [7:0] exp_q [$];
  string      exp_tag = "R5";
  event       obs_ev;
  logic [7:0] obs_byte;
  logic [7:0] wdat [16];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    wq(Q);
    m_scl = 1'b1; wq(2 * Q);
    m_scl = 1'b0; wq(Q);
  endtask

  // ack counts only if the line is low through the whole high phase
  task automatic get_ack(output bit held);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1;
    held = 1'b1;
    for (int k = 0; k < 2 * Q; k++) begin
      wq(1);
      if (sda_line) held = 1'b0;
    end
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_ack(ack);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      d = {d[6:0], sda_line};
      wq(Q);
      m_scl = 1'b0; wq(Q);
    end
    send_bit(!give_ack);
  endtask

  task automatic write_txn(input logic [6:0] a, input int n, input string req);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    check(ack, "R2 write device byte", ack, 1);
    send_byte({1'b0, a}, ack);
    check(ack, "R4 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wdat[i], ack);
      check(ack, req, ack, 1);
    end
    bus_stop();
  endtask

  // driver side of the scoreboard: caller pushes expected bytes first
  task automatic read_txn(input logic [6:0] a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    exp_tag = req;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    check(ack, "R2 device byte before read", ack, 1);
    send_byte({1'b0, a}, ack);
    check(ack, "R4 word address before read", ack, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check(ack, "R2 read device byte", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      obs_byte = d;
      ->obs_ev;
    end
    check(!sda_oe && sda_line, "R6 released after master nack", {sda_oe, sda_line}, 2'b01);
    bus_stop();
  endtask

  task automatic probe_ack(input bit expect_ack, input string req);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    check(ack == expect_ack, req, ack, expect_ack);
    bus_stop();
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, exp_tag, obs_byte, 32'hFFFF);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(obs_byte == e, exp_tag, obs_byte, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit ack;
    wq(5);
    check(sda_oe == 1'b0, "R1 during reset", sda_oe, 0);
    rst = 1'b0;
    wq(1);
    check(sda_oe == 1'b0, "R1 after reset", sda_oe, 0);
    wq(10);

    // R3: foreign address
    bus_start();
    send_byte({7'h51, 1'b0}, ack);
    check(!ack, "R3 mismatched address acked", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R3 stays off bus after mismatch", ack, 0);
    bus_stop();
    wq(4 * Q);

    // R2/R4/R9: small write then read back
    wdat[0] = 8'h3C; wdat[1] = 8'hA5; wdat[2] = 8'h0F;
    write_txn(7'd5, 3, "R4 data byte ack");
    wq(PROG + 100);
    exp_q.push_back(8'h3C); exp_q.push_back(8'hA5); exp_q.push_back(8'h0F);
    read_txn(7'd5, 3, "R5 sequential read of written bytes");

    // R8/R9: lockout during programming, recovery afterwards
    wdat[0] = 8'h77;
    write_txn(7'd40, 1, "R4 single data ack");
    probe_ack(1'b0, "R8 ack while programming");
    wq(PROG + 100);
    probe_ack(1'b1, "R9 ack after programming window");
    exp_q.push_back(8'h77);
    read_txn(7'd40, 1, "R9 programmed byte");

    // R10: START part-way through a write discards it
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'd40, ack);
    send_byte(8'h11, ack);
    check(ack, "R4 data ack before abort", ack, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    bus_stop();
    probe_ack(1'b1, "R10 no programming after abort");
    exp_q.push_back(8'h77);
    read_txn(7'd40, 1, "R10 array unchanged after abort");

    // R11: STOP right after the word address
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'd60, ack);
    bus_stop();
    probe_ack(1'b1, "R11 no programming without data");

    // R7: ten bytes, last eight kept oldest-first
    for (int i = 0; i < 10; i++) wdat[i] = 8'hA0 + 8'(i);
    write_txn(7'd16, 10, "R7 overflow byte ack");
    wq(PROG + 100);
    for (int i = 2; i < 10; i++) exp_q.push_back(8'hA0 + 8'(i));
    read_txn(7'd16, 8, "R7 last eight bytes in order");

    // R12/R5: write and read across the 127 -> 0 boundary
    wdat[0] = 8'hC1; wdat[1] = 8'hC2; wdat[2] = 8'hC3;
    write_txn(7'd126, 3, "R12 wrapping write ack");
    wq(PROG + 100);
    exp_q.push_back(8'hC1); exp_q.push_back(8'hC2); exp_q.push_back(8'hC3);
    read_txn(7'd126, 3, "R12 R5 wrap across top address");
    exp_q.push_back(8'hC3);
    read_txn(7'd0, 1, "R12 byte landed at address 0");

    wq(20);
    check(exp_q.size() == 0, "R5 all expected bytes observed", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule